// File: doc/BRIEF.md
# USB PHY Interrupt Event Detector

This block watches five status lines reported by a USB PHY (ID-ground, session-end, session-valid, VBUS-valid and host-disconnect). It raises interrupt events when one of those lines makes a rising or falling transition that software has enabled. Each line has its own rising-edge enable bit and falling-edge enable bit. Both enable registers are reached through a small register interface. Each register has two write addresses: one where a 1 sets enable bits, and one where a 1 clears them. Detected events are latched into a sticky status register, cleared by writing 1, and the status bits are ORed into a single interrupt line.

Two lines need qualification. The ID-ground line floats while the ID pull-up is off and settles slowly after the pull-up is turned on. Its events are therefore suppressed while the pull-up control is low and for a configurable settling window (50 ms by default) after it goes high. The window is timed by a cycle counter derived from the clock frequency. Host-disconnect events count only in host mode, which means both data-line pull-down controls are high. The PHY lines are asynchronous and are synchronized inside the block. The pull-up and pull-down controls are assumed to come from registers in the same clock domain.

Top module: `usb_phy_evt_det`

## Requirements
- R1: The status lines map to bit positions as follows: `phy_lines[4]` ID-ground, `[3]` session-end, `[2]` session-valid, `[1]` VBUS-valid, `[0]` host-disconnect. Enable and status registers use the same bit positions.
- R2: Bits 7..5 of every register read as 0, and writes to them have no effect. Reads of addresses 5..7 return 0.
- R3: A line's status bit is set by a 0-to-1 transition only when its rising-enable bit is 1, and by a 1-to-0 transition only when its falling-enable bit is 1. A disabled transition sets nothing.
- R4: Register map: address 0 is the rising-enable set alias and address 1 is its clear alias. Address 2 is the falling-enable set alias and address 3 is its clear alias. Address 4 is the status register. On a clear alias, writing 1 to a bit clears that enable bit and writing 0 leaves it unchanged. Reads of addresses 0 and 1 return the rising enables, reads of 2 and 3 return the falling enables, and reads of 4 return the status.
- R5: ID-ground transitions (both edges) set nothing while `id_pullup` is 0.
- R6: ID-ground transitions are also ignored for `MASK_MS` milliseconds (`CLK_HZ/1000*MASK_MS` cycles) after `id_pullup` goes from 0 to 1. The window restarts if `id_pullup` drops and rises again during it.
- R7: Host-disconnect transitions set status only while `dp_pulldown` and `dm_pulldown` are both 1.
- R8: After reset, the rising enables read 0x00, the falling enables read 0x1F, the status reads 0x00 and `irq` is 0.
- R9: On a set alias, writing 1 to a bit sets that enable bit and writing 0 leaves it unchanged.
- R10: Status bits are sticky. Writing 1 to a bit at address 4 clears it, and writing 0 has no effect. `irq` is 1 exactly when some status bit is 1.
- R11: If a status-bit clear and a new event for the same bit fall in the same cycle, the bit stays set.
- R12: Each line passes through a two-flop synchronizer. A transition presented before clock edge k is visible in status and `irq` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_lines | input | 5 | Asynchronous PHY status lines (bit map in R1) |
| id_pullup | input | 1 | ID pull-up control |
| dp_pulldown | input | 1 | D+ pull-down control |
| dm_pulldown | input | 1 | D- pull-down control |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt, OR of the status bits |

## Verification
A status clear written by software can land on the same edge as a newly detected event on that bit. To provoke this, the bench changes a line and then times a write-1-to-clear so that it is captured on the third edge, the same edge that latches the synchronized transition. The check passes only if the bit and `irq` are still set afterwards, and a second clear then removes both. The ID settling timer can also be restarted during its window, and the bench checks that the masking still tracks the latest pull-up rise.

// File: rtl/usb_evt_pkg.sv
// Package: shared widths, bit positions and register addresses for the
// USB PHY interrupt event detector.
package usb_evt_pkg;
    localparam int NSIG = 5;
    localparam int DW   = 8;
    localparam int AW   = 3;

    localparam int BIT_ID    = 4;
    localparam int BIT_HDISC = 0;

    localparam logic [AW-1:0] A_RISE_SET = 3'd0;
    localparam logic [AW-1:0] A_RISE_CLR = 3'd1;
    localparam logic [AW-1:0] A_FALL_SET = 3'd2;
    localparam logic [AW-1:0] A_FALL_CLR = 3'd3;
    localparam logic [AW-1:0] A_STATUS   = 3'd4;
endpackage

// File: rtl/usb_line_sync.sv
// Module: two-flop synchronizer plus one history flop per line.
// Assumes: inputs are asynchronous levels; output cur is the synchronized
// value and prv its value one cycle earlier, for edge detection.
module usb_line_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta;

    // Purpose: shift each line through meta -> cur -> prv.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            cur  <= '0;
            prv  <= '0;
        end else begin
            meta <= d;
            cur  <= meta;
            prv  <= cur;
        end
    end
endmodule

// File: rtl/usb_id_mask_timer.sv
// Module: produces the ID-ground event mask.
// Assumes: id_pullup is synchronous to clk. The mask is active while the
// pull-up is off, on the cycle it rises, and for TICKS cycles afterwards.
// A drop of the pull-up during the window restarts the window on the next rise.
module usb_id_mask_timer #(
    parameter int CLK_HZ  = 200_000_000,
    parameter int MASK_MS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic id_pullup,
    output logic id_masked
);
    localparam int TICKS = (CLK_HZ / 1000) * MASK_MS;
    localparam int CW    = $clog2(TICKS + 1);

    logic          pu_q;
    logic [CW-1:0] cnt;

    // Purpose: track the pull-up level and count down the settling window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_q <= 1'b0;
            cnt  <= '0;
        end else begin
            pu_q <= id_pullup;
            if (!id_pullup)
                cnt <= '0;
            else if (!pu_q)
                cnt <= CW'(TICKS);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // Purpose: mask while off, during the rise cycle, or while counting.
    always_comb id_masked = !id_pullup || !pu_q || (cnt != '0);
endmodule

// File: rtl/usb_en_reg.sv
// Module: enable register with a set alias and a clear alias.
// Assumes: set_we and clr_we come from distinct addresses, so they are never
// both high; a 1 in d sets or clears the bit and a 0 leaves it alone.
module usb_en_reg #(
    parameter int          W   = 5,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: apply set-by-one and clear-by-one writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST;
        else if (set_we)
            q <= q | d;
        else if (clr_we)
            q <= q & ~d;
    end
endmodule

// File: rtl/usb_phy_evt_det.sv
// Module: top of the USB PHY interrupt event detector.
// Assumes: phy_lines are asynchronous; pull-up/pull-down controls and the
// register interface are synchronous to clk. Reads are combinational.
module usb_phy_evt_det
    import usb_evt_pkg::*;
#(
    parameter int CLK_HZ  = 200_000_000,
    parameter int MASK_MS = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NSIG-1:0] phy_lines,
    input  logic          id_pullup,
    input  logic          dp_pulldown,
    input  logic          dm_pulldown,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    logic [NSIG-1:0] cur, prv, rise_en, fall_en, status, qual, evt;
    logic [NSIG-1:0] wd, stat_clr;
    logic            id_masked, host_mode, unused_hi;

    assign wd        = reg_wdata[NSIG-1:0];
    assign unused_hi = ^reg_wdata[DW-1:NSIG];

    usb_line_sync #(.W(NSIG)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(phy_lines), .cur(cur), .prv(prv)
    );

    usb_id_mask_timer #(.CLK_HZ(CLK_HZ), .MASK_MS(MASK_MS)) u_idt (
        .clk(clk), .rst_n(rst_n), .id_pullup(id_pullup), .id_masked(id_masked)
    );

    usb_en_reg #(.W(NSIG), .RST('0)) u_rise (
        .clk(clk), .rst_n(rst_n),
        .set_we(reg_wr && reg_addr == A_RISE_SET),
        .clr_we(reg_wr && reg_addr == A_RISE_CLR),
        .d(wd), .q(rise_en)
    );

    usb_en_reg #(.W(NSIG), .RST('1)) u_fall (
        .clk(clk), .rst_n(rst_n),
        .set_we(reg_wr && reg_addr == A_FALL_SET),
        .clr_we(reg_wr && reg_addr == A_FALL_CLR),
        .d(wd), .q(fall_en)
    );

    assign host_mode = dp_pulldown && dm_pulldown;

    // Per-line qualification and edge event generation.
    for (genvar i = 0; i < NSIG; i++) begin : g_evt
        if (i == BIT_ID) begin : g_id
            assign qual[i] = !id_masked;
        end else if (i == BIT_HDISC) begin : g_hd
            assign qual[i] = host_mode;
        end else begin : g_plain
            assign qual[i] = 1'b1;
        end
        assign evt[i] = qual[i] &&
                        ((rise_en[i] && cur[i] && !prv[i]) ||
                         (fall_en[i] && !cur[i] && prv[i]));
    end

    assign stat_clr = (reg_wr && reg_addr == A_STATUS) ? wd : '0;

    // Purpose: sticky status; a new event overrides a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~stat_clr) | evt;
    end

    // Purpose: single interrupt line from all status bits.
    always_comb irq = |status;

    // Purpose: read mux; upper bits and unmapped addresses read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RISE_SET, A_RISE_CLR: reg_rdata[NSIG-1:0] = rise_en;
            A_FALL_SET, A_FALL_CLR: reg_rdata[NSIG-1:0] = fall_en;
            A_STATUS:               reg_rdata[NSIG-1:0] = status;
            default:                reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/usb_phy_evt_chk.sv
// Module: assertion checker for usb_phy_evt_det, attached by bind.
// Assumes: connected to the top's internal enable and status registers.
module usb_phy_evt_chk
    import usb_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [NSIG-1:0] wdata,
    input  logic            id_pullup,
    input  logic            dp_pulldown,
    input  logic            dm_pulldown,
    input  logic [NSIG-1:0] rise_en,
    input  logic [NSIG-1:0] fall_en,
    input  logic [NSIG-1:0] status,
    input  logic            irq
);
    p_rise_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_RISE_CLR) |=> ((rise_en & $past(wdata)) == '0));

    p_fall_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_FALL_CLR) |=> ((fall_en & $past(wdata)) == '0));

    p_rise_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_RISE_SET) |=> ((rise_en & $past(wdata)) == $past(wdata)));

    p_id_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[BIT_ID]) |-> $past(id_pullup));

    p_host_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[BIT_HDISC]) |-> $past(dp_pulldown && dm_pulldown));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_STATUS) |=> (($past(status) & ~status) == '0));

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_addr == A_STATUS)) |=> irq);
endmodule

bind usb_phy_evt_det usb_phy_evt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wdata(reg_wdata[4:0]), .id_pullup(id_pullup),
    .dp_pulldown(dp_pulldown), .dm_pulldown(dm_pulldown),
    .rise_en(rise_en), .fall_en(fall_en), .status(status), .irq(irq)
);

// File: tb/sim_usb_phy_evt_det.sv
`timescale 1ns/1ps
module sim_usb_phy_evt_det;
    localparam int CLK_HZ  = 1000;
    localparam int MASK_MS = 50;
    localparam int TICKS   = CLK_HZ / 1000 * MASK_MS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] phy_lines = '0;
    logic       id_pullup = 1'b0, dp_pulldown = 1'b0, dm_pulldown = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    usb_phy_evt_det #(.CLK_HZ(CLK_HZ), .MASK_MS(MASK_MS)) u0 (
        .clk(clk), .rst_n(rst_n), .phy_lines(phy_lines), .id_pullup(id_pullup),
        .dp_pulldown(dp_pulldown), .dm_pulldown(dm_pulldown), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // {lines, expected status}; rising and falling all enabled, host mode on.
    localparam logic [9:0] TBL [10] = '{
        {5'b00000, 5'b00000}, {5'b00001, 5'b00001}, {5'b00011, 5'b00010},
        {5'b00010, 5'b00001}, {5'b11100, 5'b11110}, {5'b11100, 5'b00000},
        {5'b00000, 5'b11100}, {5'b10101, 5'b10101}, {5'b01010, 5'b11111},
        {5'b00000, 5'b01010}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic drive(input logic [4:0] v);
        phy_lines = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R8 reset values
        rd(3'd0, v); chk("R8 rise reset", v, 8'h00);
        rd(3'd2, v); chk("R8 fall reset", v, 8'h1F);
        rd(3'd4, v); chk("R8 status reset", v, 8'h00);
        chk("R8 irq reset", {7'd0, irq}, 8'h00);

        // R9 / R2 set alias, reserved bits
        wr(3'd0, 8'hFF); rd(3'd1, v); chk("R9 R2 set alias", v, 8'h1F);
        wr(3'd1, 8'hE0); rd(3'd0, v); chk("R2 reserved clr ignored", v, 8'h1F);
        wr(3'd1, 8'h00); rd(3'd0, v); chk("R4 clr zero no effect", v, 8'h1F);
        wr(3'd1, 8'h01); rd(3'd0, v); chk("R4 clr alias", v, 8'h1E);
        wr(3'd0, 8'h01); rd(3'd0, v); chk("R9 set back", v, 8'h1F);
        rd(3'd5, v); chk("R2 unmapped reads zero", v, 8'h00);

        // Table walk: R1 R3 R12 with host mode on and ID window expired
        id_pullup = 1'b1; dp_pulldown = 1'b1; dm_pulldown = 1'b1;
        idle(TICKS + 10);
        for (int i = 0; i < 10; i++) begin
            drive(TBL[i][9:5]);
            rd(3'd4, v); chk($sformatf("R1 R3 R12 table step %0d", i), v, {3'd0, TBL[i][4:0]});
            chk($sformatf("R10 irq table step %0d", i), {7'd0, irq}, {7'd0, |TBL[i][4:0]});
            wr(3'd4, 8'h1F);
        end

        // R12 latency: not yet visible after two edges
        phy_lines = 5'b00100;
        repeat (2) @(posedge clk); @(negedge clk);
        rd(3'd4, v); chk("R12 not before third edge", v, 8'h00);
        idle(1);
        rd(3'd4, v); chk("R12 visible at third edge", v, 8'h04);
        wr(3'd4, 8'h00); rd(3'd4, v); chk("R10 write zero keeps", v, 8'h04);
        wr(3'd4, 8'h04); rd(3'd4, v); chk("R10 write one clears", v, 8'h00);
        chk("R10 irq low", {7'd0, irq}, 8'h00);
        drive(5'b00000); wr(3'd4, 8'h1F);

        // R5 pull-up off masks both edges
        id_pullup = 1'b0; idle(2);
        drive(5'b10000); rd(3'd4, v); chk("R5 rise masked", v, 8'h00);
        drive(5'b00000); rd(3'd4, v); chk("R5 fall masked", v, 8'h00);
        // R6 settling window
        id_pullup = 1'b1; idle(1);
        drive(5'b10000); rd(3'd4, v); chk("R6 masked in window", v, 8'h00);
        drive(5'b00000); rd(3'd4, v); chk("R6 fall masked in window", v, 8'h00);
        idle(TICKS + 10);
        drive(5'b10000); rd(3'd4, v); chk("R6 event after window", v, 8'h10);
        wr(3'd4, 8'h1F);
        // R6 restart
        id_pullup = 1'b0; idle(2);
        id_pullup = 1'b1; idle(TICKS - 10);
        id_pullup = 1'b0; idle(1);
        id_pullup = 1'b1; idle(TICKS - 10);
        drive(5'b00000); rd(3'd4, v); chk("R6 window restarted", v, 8'h00);
        idle(20);
        drive(5'b10000); rd(3'd4, v); chk("R6 after restarted window", v, 8'h10);
        wr(3'd4, 8'h1F);

        // R7 host-mode qualification
        dp_pulldown = 1'b0; dm_pulldown = 1'b0;
        drive(5'b10001); rd(3'd4, v); chk("R7 no pulldowns", v, 8'h00);
        drive(5'b10000); rd(3'd4, v); chk("R7 no pulldowns fall", v, 8'h00);
        dp_pulldown = 1'b1;
        drive(5'b10001); rd(3'd4, v); chk("R7 one pulldown", v, 8'h00);
        drive(5'b10000);
        dm_pulldown = 1'b1;
        drive(5'b10001); rd(3'd4, v); chk("R7 host mode", v, 8'h01);
        wr(3'd4, 8'h1F);

        // R3 disabled rising edge, R4 clear alias in effect
        wr(3'd1, 8'h02);
        drive(5'b10011); rd(3'd4, v); chk("R3 rise disabled", v, 8'h00);
        drive(5'b10001); rd(3'd4, v); chk("R3 fall enabled", v, 8'h02);
        wr(3'd4, 8'h1F);

        // R11 clear and event on the same edge
        phy_lines = 5'b10000;
        repeat (2) @(posedge clk); @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h01;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
        rd(3'd4, v); chk("R11 event wins", v, 8'h01);
        chk("R11 irq kept", {7'd0, irq}, 8'h01);
        wr(3'd4, 8'h01); rd(3'd4, v); chk("R11 later clear", v, 8'h00);
        chk("R10 irq cleared", {7'd0, irq}, 8'h00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule